// File: doc/BRIEF.md
# Iterative Ten-Bit-Per-Cycle Integer Multiplier

This block multiplies two integer operands over several clock cycles. On each step it takes ten bits of the multiplier. The ten partial products they select, together with the partly reduced result of the previous step, are compressed in a carry-save array into one sum vector and one carry vector. The ten lowest bits of that pair are resolved at once and stored as finished low product bits. The rest of the pair is registered as the two inputs of one shared carry-propagate adder. That adder's output is the feedback term for the next step. After the last step it also provides the upper part of the product. The array itself contains no final adder.

The operand width can be set to 24, 32, 54 or 64 bits, and the operands can be signed or unsigned. In unsigned mode each operand gets one extra zero bit. Because of that extra bit, a full 64-bit unsigned product still fits the seven-step schedule. A caller pulses `start_i` with both operands, a width code and a sign flag. The block raises `done_o` for one cycle, and in that cycle the high and low halves of the product appear on `hi_o` and `lo_o`.

Top module: `mul_iter`

## Requirements
- R1: While `rst_n` is low, `hi_o`, `lo_o` and `done_o` read zero one clock edge later.
- R2: A start is accepted on a rising clock edge where `start_i` is high and no operation is in progress. `a_i`, `b_i`, `wsel_i` and `sgn_i` are sampled on that edge only, and later changes to them do not alter the result. Width codes are 0 = 24 bits, 1 = 32 bits, 2 = 54 bits, 3 = 64 bits.
- R3: `done_o` is high for exactly one cycle. It rises on the edge that comes L edges after the accepting edge, with L = 3, 4, 6 or 7 for width code 0, 1, 2 or 3.
- R4: With `sgn_i` = 1, the operands are the W-bit two's-complement values `a_i[W-1:0]` and `b_i[W-1:0]`. Let p be their exact 2W-bit product. Then `lo_o[W-1:0]` = p[W-1:0] and `hi_o[W-1:0]` = p[2W-1:W], and bits W..63 of both outputs are zero.
- R5: With `sgn_i` = 0, the operands are unsigned W-bit values and the output layout is the same as in R4. This includes a full 128-bit product for W = 64.
- R6: Operand bits at position W and above have no effect on the result.
- R7: A start that arrives while an operation is in progress is ignored, including in the cycle of the final add. A start in the cycle where `done_o` is high is accepted.
- R8: `hi_o` and `lo_o` change only on the edge that raises `done_o`, and otherwise hold their values.
- R9: Corner operands give exact results in every width and sign mode: zero, all ones, and the most negative value times itself, which in signed mode gives 2^(2W-2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Requests a new multiplication |
| a_i | input | 64 | Multiplicand; low W bits used |
| b_i | input | 64 | Multiplier; low W bits used |
| wsel_i | input | 2 | Width code: 0=24, 1=32, 2=54, 3=64 bits |
| sgn_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| hi_o | output | 64 | Upper W bits of the product, zero above |
| lo_o | output | 64 | Lower W bits of the product, zero above |
| done_o | output | 1 | One-cycle strobe: result valid on hi_o/lo_o |

## Verification
Two events can fall in the same cycle: the completion strobe of one product and the acceptance of the next start. A third case is a start that arrives in the final-add cycle, just before the strobe. The bench provokes all three by holding `start_i` high for a long run while it changes the operands and width code on every cycle. The behavioural model accepts an operation only when its own countdown shows the block idle. It then predicts `done_o`, `hi_o` and `lo_o` for every cycle. A start that is wrongly taken or wrongly dropped shows up as a strobe in the wrong cycle or as a result for the wrong operands.

// File: rtl/mul_pkg.sv
`timescale 1ns/1ps
// mul_pkg: shared constants, sequencing state type and operand helpers for
// the iterative multiplier. Assumes at most 64-bit operands and a retire rate
// of GRP bits per step.
package mul_pkg;
    localparam int OPW  = 64;             // widest operand
    localparam int GRP  = 10;             // multiplier bits retired per step
    localparam int MAXG = (OPW + GRP) / GRP; // steps for widest unsigned case
    localparam int XW   = GRP * MAXG;     // extended operand width
    localparam int PW   = XW + GRP;       // carry-save vector width
    localparam int RW   = PW - GRP;       // shared adder width
    localparam int CW   = $clog2(MAXG + 1);
    localparam int FW   = 2 * OPW;        // full product width

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} mul_state_e;

    // Operand width in bits for a width code.
    function automatic int width_of(input logic [1:0] code);
        case (code)
            2'd0:    return 24;
            2'd1:    return 32;
            2'd2:    return 54;
            default: return 64;
        endcase
    endfunction

    // Number of steps: enough groups for W+1 bits (unsigned needs the extra bit).
    function automatic int groups_of(input logic [1:0] code);
        return (width_of(code) + GRP) / GRP;
    endfunction

    // Sign- or zero-extend the low W bits of x to XW bits.
    function automatic logic [XW-1:0] extend(input logic [OPW-1:0] x,
                                             input logic [1:0] code,
                                             input logic sgn);
        int  n;
        logic fill;
        logic [XW-1:0] r;
        n    = width_of(code);
        fill = sgn & x[n-1];
        for (int i = 0; i < OPW; i++) r[i] = (i < n) ? x[i] : fill;
        for (int i = OPW; i < XW; i++) r[i] = fill;
        return r;
    endfunction
endpackage

// File: rtl/mul_pp_gen.sv
`timescale 1ns/1ps
// mul_pp_gen: builds the carry-save inputs for one step. These are GRP shifted
// copies of the multiplicand gated by the multiplier bits, the feedback term
// and a +1 correction. When neg_top is set, the top bit of the group has
// negative weight (two's complement top group), realised as ~x plus 1.
module mul_pp_gen #(
    parameter int XW  = 70,
    parameter int GRP = 10,
    parameter int PW  = XW + GRP,
    parameter int NT  = GRP + 2
) (
    input  logic [XW-1:0] mcand_i,
    input  logic [GRP-1:0] grp_i,
    input  logic          neg_top_i,
    input  logic [XW-1:0] fb_i,
    output logic [PW-1:0] terms_o [NT]
);
    logic [PW-1:0] base;
    assign base = {{GRP{mcand_i[XW-1]}}, mcand_i};

    // One gated, shifted multiplicand per multiplier bit.
    for (genvar i = 0; i < GRP; i++) begin : g_pp
        if (i == GRP - 1) begin : g_top
            assign terms_o[i] = !grp_i[i] ? '0 :
                                neg_top_i ? ~(base << i) : (base << i);
        end else begin : g_low
            assign terms_o[i] = grp_i[i] ? (base << i) : '0;
        end
    end

    // Feedback from the shared adder, sign-extended.
    assign terms_o[GRP]   = {{GRP{fb_i[XW-1]}}, fb_i};
    // Completes the negation of the top partial product.
    assign terms_o[GRP+1] = {{(PW-1){1'b0}}, neg_top_i & grp_i[GRP-1]};
endmodule

// File: rtl/mul_csa_array.sv
`timescale 1ns/1ps
// mul_csa_array: linear chain of 3:2 compressors that reduces N vectors to a
// sum/carry pair with no carry propagation. All arithmetic is modulo 2^W.
module mul_csa_array #(
    parameter int W = 80,
    parameter int N = 12
) (
    input  logic [W-1:0] terms_i [N],
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);
    logic [W-1:0] s_v [N-1];
    logic [W-1:0] c_v [N-1];

    assign s_v[0] = terms_i[0];
    assign c_v[0] = terms_i[1];

    // Each level folds one more input into the running pair.
    for (genvar i = 1; i < N - 1; i++) begin : g_lvl
        logic [W-1:0] x;
        logic [W-1:0] maj;
        assign x      = terms_i[i+1];
        assign maj    = (s_v[i-1] & c_v[i-1]) | (s_v[i-1] & x) | (c_v[i-1] & x);
        assign s_v[i] = s_v[i-1] ^ c_v[i-1] ^ x;
        assign c_v[i] = maj << 1;
    end

    assign sum_o   = s_v[N-2];
    assign carry_o = c_v[N-2];
endmodule

// File: rtl/mul_cpa.sv
`timescale 1ns/1ps
// mul_cpa: the single carry-propagate adder shared by every step. It resolves
// the registered sum/carry pair plus a carry-in from the low retired bits.
module mul_cpa #(
    parameter int W = 70
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] y_o
);
    assign y_o = a_i + b_i + {{(W-1){1'b0}}, cin_i};
endmodule

// File: rtl/mul_iter.sv
`timescale 1ns/1ps
// mul_iter: iterative multiplier that retires GRP product bits per clock.
// Step 0 runs on the accepting edge from the input operands. The remaining
// steps use stored operands, with the shared adder's result fed back. One
// extra cycle resolves the last pair through that adder and loads HI/LO.
// Assumes: a start is honoured only while idle; inputs matter only on that edge.
module mul_iter
    import mul_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [OPW-1:0]   a_i,
    input  logic [OPW-1:0]   b_i,
    input  logic [1:0]       wsel_i,
    input  logic             sgn_i,
    output logic [OPW-1:0]   hi_o,
    output logic [OPW-1:0]   lo_o,
    output logic             done_o
);
    localparam int NT = GRP + 2;

    mul_state_e      state_q;
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   last_q;
    logic [1:0]      wsel_q;
    logic [XW-1:0]   a_q;
    logic [XW-GRP-1:0] b_q;
    logic [RW-1:0]   s_q;
    logic [RW-1:0]   t_q;
    logic            cin_q;
    logic [XW-1:0]   lo_sh;
    logic [OPW-1:0]  hi_q;
    logic [OPW-1:0]  lo_q;
    logic            done_q;

    logic            accept;
    logic [XW-1:0]   a_ext;
    logic [XW-1:0]   b_ext;
    logic [XW-1:0]   cur_a;
    logic [GRP-1:0]  cur_grp;
    logic            neg_top;
    logic [RW-1:0]   r_sum;
    logic [XW-1:0]   fb;
    logic [PW-1:0]   terms [NT];
    logic [PW-1:0]   sum_w;
    logic [PW-1:0]   carry_w;
    logic [GRP-1:0]  lo_bits;
    logic            lo_c;
    logic [FW-1:0]   full;
    logic [OPW-1:0]  hi_n;
    logic [OPW-1:0]  lo_n;

    // Operand selection: live inputs on the accepting edge, stored values after.
    always_comb begin
        accept  = start_i && (state_q == ST_IDLE);
        a_ext   = extend(a_i, wsel_i, sgn_i);
        b_ext   = extend(b_i, wsel_i, sgn_i);
        cur_a   = accept ? a_ext : a_q;
        cur_grp = accept ? b_ext[GRP-1:0] : b_q[GRP-1:0];
        neg_top = (state_q == ST_RUN) && (cnt_q == last_q);
        fb      = accept ? '0 : r_sum;
    end

    mul_pp_gen #(.XW(XW), .GRP(GRP), .PW(PW), .NT(NT)) u_pp (
        .mcand_i   (cur_a),
        .grp_i     (cur_grp),
        .neg_top_i (neg_top),
        .fb_i      (fb),
        .terms_o   (terms)
    );

    mul_csa_array #(.W(PW), .N(NT)) u_csa (
        .terms_i (terms),
        .sum_o   (sum_w),
        .carry_o (carry_w)
    );

    mul_cpa #(.W(RW)) u_cpa (
        .a_i   (s_q),
        .b_i   (t_q),
        .cin_i (cin_q),
        .y_o   (r_sum)
    );

    // Resolve the ten retired low bits; their carry goes to the shared adder.
    always_comb begin
        {lo_c, lo_bits} = {1'b0, sum_w[GRP-1:0]} + {1'b0, carry_w[GRP-1:0]};
    end

    // Assemble the product and cut it into halves for the selected width.
    always_comb begin
        full = ({{(FW-RW){r_sum[RW-1]}}, r_sum} << (GRP * (int'(last_q) + 1)))
             | {{(FW-XW){1'b0}}, lo_sh};
        hi_n = '0;
        lo_n = '0;
        case (wsel_q)
            2'd0: begin
                lo_n[23:0] = full[23:0];
                hi_n[23:0] = full[47:24];
            end
            2'd1: begin
                lo_n[31:0] = full[31:0];
                hi_n[31:0] = full[63:32];
            end
            2'd2: begin
                lo_n[53:0] = full[53:0];
                hi_n[53:0] = full[107:54];
            end
            default: begin
                lo_n = full[63:0];
                hi_n = full[127:64];
            end
        endcase
    end

    // Sequencer and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            last_q  <= '0;
            wsel_q  <= '0;
            a_q     <= '0;
            b_q     <= '0;
            s_q     <= '0;
            t_q     <= '0;
            cin_q   <= 1'b0;
            lo_sh   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_RUN;
                        cnt_q   <= CW'(1);
                        last_q  <= CW'(groups_of(wsel_i) - 1);
                        wsel_q  <= wsel_i;
                        a_q     <= a_ext;
                        b_q     <= b_ext[XW-1:GRP];
                        s_q     <= sum_w[PW-1:GRP];
                        t_q     <= carry_w[PW-1:GRP];
                        cin_q   <= lo_c;
                        lo_sh   <= {{(XW-GRP){1'b0}}, lo_bits};
                    end
                end
                ST_RUN: begin
                    s_q   <= sum_w[PW-1:GRP];
                    t_q   <= carry_w[PW-1:GRP];
                    cin_q <= lo_c;
                    lo_sh[GRP*int'(cnt_q) +: GRP] <= lo_bits;
                    b_q   <= b_q >> GRP;
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == last_q) state_q <= ST_FIN;
                end
                default: begin
                    hi_q    <= hi_n;
                    lo_q    <= lo_n;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign hi_o   = hi_q;
    assign lo_o   = lo_q;
    assign done_o = done_q;
endmodule

// File: rtl/mul_iter_chk.sv
`timescale 1ns/1ps
// mul_iter_chk: port-level protocol checker for mul_iter. It keeps its own
// record of whether an operation is open and how many edges have passed.
module mul_iter_chk
    import mul_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [1:0]     wsel_i,
    input logic           done_o,
    input logic [OPW-1:0] hi_o,
    input logic [OPW-1:0] lo_o
);
    logic       busy_q;
    logic [3:0] lat_q;
    logic [3:0] want_q;

    // Track open operation and elapsed edges since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            lat_q  <= '0;
            want_q <= '0;
        end else if (start_i && (!busy_q || done_o)) begin
            busy_q <= 1'b1;
            lat_q  <= '0;
            want_q <= 4'(groups_of(wsel_i));
        end else if (done_o) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            lat_q <= lat_q + 4'd1;
        end
    end

    // R3: the strobe lasts one cycle.
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: the strobe arrives after the latency for the accepted width.
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_q && lat_q == want_q));

    // R7: a strobe only ever closes an accepted operation.
    p_done_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !done_o);

    // R8: results hold outside the strobe cycle.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(hi_o) && $stable(lo_o)));
endmodule

bind mul_iter mul_iter_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .wsel_i  (wsel_i),
    .done_o  (done_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
);

// File: tb/mul_iter_tb.sv
`timescale 1ns/1ps
// mul_iter_tb: behavioural reference model updated on each rising edge,
// compared against the design on every falling edge.
module mul_iter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic [1:0]  wsel = '0;
    logic        sgn = 1'b0;
    logic [63:0] hi;
    logic [63:0] lo;
    logic        done;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    checking = 1'b0;
    bit    finished = 1'b0;
    string cur_tag = "R4";

    // model state
    bit          m_busy = 1'b0;
    int          m_left = 0;
    bit          exp_done = 1'b0;
    logic [63:0] exp_hi = '0;
    logic [63:0] exp_lo = '0;
    logic [63:0] pend_hi = '0;
    logic [63:0] pend_lo = '0;
    string       pend_tag = "R4";
    string       done_tag = "R4";

    always #2 clk = ~clk;   // 250 MHz

    mul_iter u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .a_i     (a),
        .b_i     (b),
        .wsel_i  (wsel),
        .sgn_i   (sgn),
        .hi_o    (hi),
        .lo_o    (lo),
        .done_o  (done)
    );

    function automatic int wbits(input logic [1:0] c);
        case (c)
            2'd0: return 24;
            2'd1: return 32;
            2'd2: return 54;
            default: return 64;
        endcase
    endfunction

    function automatic int wlat(input logic [1:0] c);
        case (c)
            2'd0: return 3;
            2'd1: return 4;
            2'd2: return 6;
            default: return 7;
        endcase
    endfunction

    function automatic logic [127:0] ext128(input logic [63:0] x, input int w, input bit s);
        logic [127:0] r;
        logic [127:0] m;
        m = (128'd1 << w) - 128'd1;
        r = {64'd0, x} & m;
        if (s && x[w-1]) r = r | ~m;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference model: acceptance, countdown and expected result per edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_left = 0; exp_done = 1'b0;
            exp_hi = '0; exp_lo = '0;
        end else begin
            exp_done = 1'b0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 1'b0; exp_done = 1'b1;
                    exp_hi = pend_hi; exp_lo = pend_lo; done_tag = pend_tag;
                end
            end else if (start) begin
                int w;
                logic [127:0] p;
                logic [127:0] m;
                logic [127:0] ph;
                w  = wbits(wsel);
                m  = (128'd1 << w) - 128'd1;
                p  = ext128(a, w, sgn) * ext128(b, w, sgn);
                ph = (p >> w) & m;
                pend_lo  = p[63:0] & m[63:0];
                pend_hi  = ph[63:0];
                pend_tag = cur_tag;
                m_busy = 1'b1;
                m_left = wlat(wsel);
            end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (checking) begin
            if (!rst_n) begin
                chk(done == 1'b0, "R1", "done in reset", {127'd0, done}, 128'd0);
                chk(hi == 64'd0 && lo == 64'd0, "R1", "hi:lo in reset", {hi, lo}, 128'd0);
            end else begin
                chk(done == exp_done, exp_done ? done_tag : "R3", "done",
                    {127'd0, done}, {127'd0, exp_done});
                chk(hi == exp_hi, exp_done ? done_tag : "R8", "hi",
                    {64'd0, hi}, {64'd0, exp_hi});
                chk(lo == exp_lo, exp_done ? done_tag : "R8", "lo",
                    {64'd0, lo}, {64'd0, exp_lo});
            end
        end
    end

    // One operation; the operands are scrambled right after acceptance (R2).
    task automatic op(input logic [63:0] av, input logic [63:0] bv,
                      input logic [1:0] wc, input bit s, input string tag);
        @(negedge clk);
        cur_tag = tag;
        a = av; b = bv; wsel = wc; sgn = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a = {$urandom, $urandom}; b = {$urandom, $urandom};
        wsel = 2'($urandom); sgn = 1'($urandom);
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [63:0] mask_w(input int w);
        logic [127:0] m;
        m = (128'd1 << w) - 128'd1;
        return m[63:0];
    endfunction

    initial begin
        repeat (2) @(negedge clk);
        checking = 1'b1;            // R1 checks while reset is low
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int wc = 0; wc < 4; wc++) begin
            for (int s = 0; s < 2; s++) begin
                int w;
                logic [63:0] mn;
                logic [63:0] ones;
                string tg;
                w    = wbits(2'(wc));
                mn   = 64'd1 << (w - 1);
                ones = mask_w(w);
                tg   = (s != 0) ? "R4" : "R5";
                op(64'd0, {$urandom, $urandom} & ones, 2'(wc), 1'(s), "R9");   // zero
                op(ones, ones, 2'(wc), 1'(s), "R9");                           // all ones
                op(mn, mn, 2'(wc), 1'(s), "R9");                               // most negative
                op(mn, ones, 2'(wc), 1'(s), "R9");
                op(ones, 64'd1, 2'(wc), 1'(s), tg);
                for (int k = 0; k < 4; k++)
                    op({$urandom, $urandom} & ones, {$urandom, $urandom} & ones, 2'(wc), 1'(s), tg);
                // R6: garbage above the selected width
                op({$urandom, $urandom}, {$urandom, $urandom}, 2'(wc), 1'(s), "R6");
                // R2: inputs change after the accepting edge (done inside op)
                op({$urandom, $urandom} & ones, {$urandom, $urandom} & ones, 2'(wc), 1'(s), "R2");
            end
        end

        // R7: start held high with operands changing every cycle
        @(negedge clk);
        cur_tag = "R7";
        start = 1'b1;
        for (int c = 0; c < 200; c++) begin
            a = {$urandom, $urandom}; b = {$urandom, $urandom};
            wsel = 2'($urandom); sgn = 1'($urandom);
            @(negedge clk);
        end
        start = 1'b0;
        repeat (12) @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failure.
    initial begin
        #(4 * 50000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule